// File: doc/BRIEF.md
# Threshold Alarm Controller

This block watches two unsigned operands and decides on every rising clock edge whether a plant is in an alarm condition. The alarm condition holds when the first watched operand is above its upper limit and the second watched operand is below its lower limit, both at once. The decision is pure combinational logic ahead of a state register, so a new input pattern is resolved in one clock.

While in alarm, two control lines are pulled low and a data register captures the carry-preserving sum of the first operand and a third operand. While running, both control lines sit high and the data register holds whatever it last captured. All outputs come straight from flops.

Top module: `thr_alarm_fsm`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are running (`alarm_o` = 0), `ctl_x_o` = 1, `ctl_y_o` = 1 and `sum_o` = 0.
- R2: If `a_in` > 37 and `c_in` < 7 (unsigned) at a rising edge, `alarm_o` is 1 after that edge.
- R3: If that compound condition is false at a rising edge, `alarm_o` is 0 after that edge.
- R4: `a_in` equal to 37, or `c_in` equal to 7, never produces alarm.
- R5: Whenever `alarm_o` is 1, both `ctl_x_o` and `ctl_y_o` are 0.
- R6: On an edge that enters or stays in alarm, `sum_o` is loaded with `a_in` + `b_in` as a 9-bit value keeping the carry.
- R7: Whenever `alarm_o` is 0, both control lines are 1, and an edge with a false condition leaves `sum_o` unchanged.
- R8: Each edge is decided only by the inputs present at that edge: consecutive alarm edges reload `sum_o` every cycle, and a change of condition shows on the outputs after exactly one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 8 | Watched operand compared against the upper limit; also a sum operand |
| b_in | input | 8 | Sum operand |
| c_in | input | 8 | Watched operand compared against the lower limit |
| alarm_o | output | 1 | State indicator: 1 alarm, 0 running |
| ctl_x_o | output | 1 | Control line, low in alarm |
| ctl_y_o | output | 1 | Control line, low in alarm |
| sum_o | output | 9 | Captured sum, held while running |

## Verification
A wrong state bit is visible at the ports one clock after the offending edge, because the indicator and both control lines are registered copies of the decision. A wrong data capture or a missed hold shows on `sum_o` in the same cycle, and since the value persists while running it keeps showing until the next alarm edge. Boundary values of 37 and 7 and the 9-bit carry case are driven directly so that an off-by-one comparator or a truncated adder diverges from the reference model within a single cycle.

// File: rtl/thr_pkg.sv
// Package: shared widths and state encoding for the threshold alarm controller.
// Assumes: operand width is at least 6 bits so the limits fit.
package thr_pkg;
    localparam int unsigned OPND_W = 8;
    localparam int unsigned SUM_W  = OPND_W + 1;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_ALARM = 1'b1
    } thr_state_e;

    typedef enum logic {
        CMP_ABOVE = 1'b0,
        CMP_BELOW = 1'b1
    } thr_cmp_e;
endpackage

// File: rtl/thr_compare.sv
// Module: strict unsigned comparison of one operand against a fixed limit.
// MODE picks "above the limit" or "below the limit"; equality never hits.
// Assumes: LIMIT fits in W bits.
module thr_compare
    import thr_pkg::*;
#(
    parameter int unsigned W     = OPND_W,
    parameter int unsigned LIMIT = 0,
    parameter thr_cmp_e    MODE  = CMP_ABOVE
) (
    input  logic [W-1:0] value_i,
    output logic         hit_o
);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    generate
        if (MODE == CMP_ABOVE) begin : g_above
            // strict greater-than test
            always_comb hit_o = (value_i > LIM);
        end else begin : g_below
            // strict less-than test
            always_comb hit_o = (value_i < LIM);
        end
    endgenerate
endmodule

// File: rtl/thr_state_reg.sv
// Module: state register and registered control lines.
// Takes the combinational alarm decision and latches it each edge.
// Assumes: synchronous active-low reset returns to running.
module thr_state_reg
    import thr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alarm_req_i,
    output thr_state_e state_o,
    output logic       ctl_x_o,
    output logic       ctl_y_o
);
    thr_state_e next_state;

    // next state: alarm only while the request holds this cycle
    always_comb next_state = alarm_req_i ? ST_ALARM : ST_RUN;

    // state and control flops; control lines are low only in alarm
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= ST_RUN;
            ctl_x_o <= 1'b1;
            ctl_y_o <= 1'b1;
        end else begin
            state_o <= next_state;
            ctl_x_o <= (next_state == ST_RUN);
            ctl_y_o <= (next_state == ST_RUN);
        end
    end
endmodule

// File: rtl/thr_sum_reg.sv
// Module: carry-preserving adder and data register.
// Loads on an alarm edge, otherwise holds.
// Assumes: SW is OW + 1 so no carry is lost.
module thr_sum_reg #(
    parameter int unsigned OW = 8,
    parameter int unsigned SW = OW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [OW-1:0] opa_i,
    input  logic [OW-1:0] opb_i,
    output logic [SW-1:0] sum_o
);
    logic [SW-1:0] sum_next;

    // widen both operands before adding so the carry lands in the top bit
    always_comb sum_next = SW'(opa_i) + SW'(opb_i);

    // data register: clear on reset, load on alarm, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_o <= '0;
        end else if (load_i) begin
            sum_o <= sum_next;
        end
    end
endmodule

// File: rtl/thr_alarm_fsm.sv
// Module: top of the threshold alarm controller.
// Combines two strict comparators into one alarm decision, registers the
// state and control lines, and captures the sum while alarm is entered.
// Assumes: inputs are synchronous to clk.
module thr_alarm_fsm
    import thr_pkg::*;
#(
    parameter int unsigned HI_LIMIT = 37,
    parameter int unsigned LO_LIMIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPND_W-1:0] a_in,
    input  logic [OPND_W-1:0] b_in,
    input  logic [OPND_W-1:0] c_in,
    output logic              alarm_o,
    output logic              ctl_x_o,
    output logic              ctl_y_o,
    output logic [SUM_W-1:0]  sum_o
);
    logic       a_high;
    logic       c_low;
    logic       alarm_req;
    thr_state_e state;

    thr_compare #(.W(OPND_W), .LIMIT(HI_LIMIT), .MODE(CMP_ABOVE)) u_cmp_a (
        .value_i (a_in),
        .hit_o   (a_high)
    );

    thr_compare #(.W(OPND_W), .LIMIT(LO_LIMIT), .MODE(CMP_BELOW)) u_cmp_c (
        .value_i (c_in),
        .hit_o   (c_low)
    );

    // both sides of the window must hold in the same cycle
    always_comb alarm_req = a_high & c_low;

    thr_state_reg u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .alarm_req_i (alarm_req),
        .state_o     (state),
        .ctl_x_o     (ctl_x_o),
        .ctl_y_o     (ctl_y_o)
    );

    thr_sum_reg #(.OW(OPND_W), .SW(SUM_W)) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (alarm_req),
        .opa_i  (a_in),
        .opb_i  (b_in),
        .sum_o  (sum_o)
    );

    // state indicator
    always_comb alarm_o = (state == ST_ALARM);
endmodule

// File: rtl/thr_alarm_chk.sv
// Checker: port-level properties of the threshold alarm controller.
module thr_alarm_chk
    import thr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OPND_W-1:0] a_in,
    input logic [OPND_W-1:0] b_in,
    input logic [OPND_W-1:0] c_in,
    input logic              alarm_o,
    input logic              ctl_x_o,
    input logic              ctl_y_o,
    input logic [SUM_W-1:0]  sum_o
);
    // R2
    alarm_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_in > 8'd37 && c_in < 8'd7) |=> alarm_o);

    // R3
    run_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_in > 8'd37 && c_in < 8'd7) |=> !alarm_o);

    // R5
    ctl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> (!ctl_x_o && !ctl_y_o));

    // R7
    ctl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_o |-> (ctl_x_o && ctl_y_o));

    // R6
    sum_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_in > 8'd37 && c_in < 8'd7) |=>
        (sum_o == ({1'b0, $past(a_in)} + {1'b0, $past(b_in)})));

    // R7
    sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_in > 8'd37 && c_in < 8'd7) |=> $stable(sum_o));
endmodule

bind thr_alarm_fsm thr_alarm_chk i_thr_alarm_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_in    (a_in),
    .b_in    (b_in),
    .c_in    (c_in),
    .alarm_o (alarm_o),
    .ctl_x_o (ctl_x_o),
    .ctl_y_o (ctl_y_o),
    .sum_o   (sum_o)
);

// File: tb/test_thr_alarm_fsm.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock.
module test_thr_alarm_fsm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a_in = '0, b_in = '0, c_in = '0;
    logic       alarm_o, ctl_x_o, ctl_y_o;
    logic [8:0] sum_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int exp_alarm = 0;
    int exp_sum   = 0;

    thr_alarm_fsm i_thr_alarm_fsm (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .alarm_o(alarm_o), .ctl_x_o(ctl_x_o), .ctl_y_o(ctl_y_o), .sum_o(sum_o)
    );

    always #2.5 clk = ~clk;

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // compare all outputs against the model, called at a falling edge
    task automatic compare(input string tag);
        int exp_ctl;
        exp_ctl = exp_alarm ? 0 : 1;
        checks++;
        if (alarm_o !== exp_alarm[0] || ctl_x_o !== exp_ctl[0] ||
            ctl_y_o !== exp_ctl[0] || sum_o !== exp_sum[8:0]) begin
            fails++;
            $display("FAIL %s: actual alarm=%0b x=%0b y=%0b sum=%0d expected alarm=%0d x=%0d y=%0d sum=%0d",
                     tag, alarm_o, ctl_x_o, ctl_y_o, sum_o, exp_alarm, exp_ctl, exp_ctl, exp_sum);
        end
    endtask

    // drive one cycle of inputs at a falling edge, step the model, check next falling edge
    task automatic apply(input bit rn, input int a, input int b, input int c, input string tag);
        rst_n = rn; a_in = a[7:0]; b_in = b[7:0]; c_in = c[7:0];
        if (!rn) begin
            exp_alarm = 0; exp_sum = 0;
        end else if (a > 37 && c < 7) begin
            exp_alarm = 1; exp_sum = a + b;
        end else begin
            exp_alarm = 0;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        int s;
        @(negedge clk);
        apply(0, 90, 90, 0, "R1 reset");
        apply(0, 90, 90, 0, "R1 reset held");
        apply(1, 50, 10, 3, "R2 alarm entry");
        apply(1, 38, 0, 6, "R2 just inside both limits");
        apply(1, 37, 5, 0, "R4 a equals 37");
        apply(1, 200, 5, 7, "R4 c equals 7");
        apply(1, 36, 1, 1, "R3 a low");
        apply(1, 255, 255, 0, "R6 carry kept");
        apply(1, 100, 1, 2, "R8 consecutive alarm 1");
        apply(1, 100, 2, 1, "R8 consecutive alarm 2");
        apply(1, 0, 9, 9, "R7 hold while running");
        apply(1, 37, 200, 7, "R7 hold at both limits");
        apply(1, 60, 4, 0, "R5 control low");
        apply(0, 60, 4, 0, "R1 reset from alarm");
        apply(1, 12, 3, 3, "R3 running after reset");
        s = 7;
        for (int i = 0; i < 300; i++) begin
            s = (s * 69069 + 12345) & 32'h7fffffff;
            apply(1, (s >> 3) & 255, (s >> 11) & 255, (s >> 19) & 15,
                  ((s >> 3) & 255) > 37 ? "R2 sweep" : "R3 sweep");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule